// File: doc/BRIEF.md
# Configurable Programmable-Logic Output Cell

This block is one output logic cell of a small programmable array logic device. It takes eight product-term inputs from the AND array. It ORs them, either passes or inverts the result, and drives an I/O pin. It also returns a feedback signal to the AND array. Two global mode bits and one per-cell mode bit pick one of five operating modes: registered, dedicated combinatorial output, two combinatorial I/O variants, and dedicated input. A per-cell polarity bit sets the sense of the output data.

The pin is modelled as a data value plus a separate drive-enable, so a disabled buffer shows up as a deasserted enable. The feedback from the neighbouring pin, used in dedicated-output mode, enters on its own port.

Top module: `palCell`

## Requirements
- R1: Mode decode from (globalMode0, globalMode1, cellMode) is as follows. (0,1,0) is registered. (1,0,0) is dedicated output. (1,1,1) is combinatorial I/O in a non-registered device. (0,1,1) is combinatorial I/O in a registered device. (1,0,1) and every other combination is dedicated input.
- R2: In registered mode, the register captures the OR of all eight product terms (productTerms[7:0]) on the rising clock edge. pinData is the register Q, passed when invertOut=0 and inverted when invertOut=1.
- R3: In registered mode, pinDriveEn equals NOT oeN, because the output-enable pin is active low.
- R4: In registered mode, feedback equals the register Q, before the polarity is applied.
- R5: In dedicated-output mode, pinData is the OR of all eight terms, passed or inverted by invertOut, with no clock delay. pinDriveEn is 1 at all times.
- R6: In dedicated-output mode, feedback equals neighborPin.
- R7: In both combinatorial I/O modes, pinData is the OR of productTerms[6:0] only, passed or inverted by invertOut. pinDriveEn equals productTerms[7].
- R8: In both combinatorial I/O modes and in dedicated-input mode, feedback equals pinIn.
- R9: In dedicated-input mode, pinDriveEn is 0 whatever the product terms and oeN are.
- R10: A synchronous reset (rst=1 at a rising edge) clears the register to 0, and the register is 0 after reset.
- R11: In registered mode, pinData and feedback change only after a rising clock edge, never in the middle of a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous power-up reset, active high |
| globalMode0 | input | 1 | Global mode bit 0 |
| globalMode1 | input | 1 | Global mode bit 1 |
| cellMode | input | 1 | Per-cell mode bit |
| invertOut | input | 1 | Per-cell polarity: 1 inverts the output data |
| oeN | input | 1 | Output-enable pin, active low |
| productTerms | input | 8 | Product terms from the AND array |
| pinIn | input | 1 | Value seen on the cell's own I/O pin |
| neighborPin | input | 1 | Signal from the adjacent pin |
| pinData | output | 1 | Data driven onto the pin |
| pinDriveEn | output | 1 | Pin buffer enable, 1 means driven |
| feedback | output | 1 | Signal returned to the AND array |

## Verification
The checker tests the following on every cycle:
- the enable source for each decoded mode
- the feedback source
- the register capturing the previous cycle's OR result
- the clear after reset

Which mode decode is right for each of the eight bit combinations, and how polarity works in each mode, can only be shown by the bench's sweeps. The bench's reference model also covers the seven-term OR in the I/O modes: there, term 7 must not reach the data.

// File: rtl/palCellPkg.sv
package palCellPkg;
  localparam int NumTerms = 8;

  typedef enum logic [2:0] {
    ModeReg      = 3'd0,
    ModeCombOut  = 3'd1,
    ModeIoNonReg = 3'd2,
    ModeIoReg    = 3'd3,
    ModeInput    = 3'd4
  } cellMode_e;

  typedef struct packed {
    logic useReg;      // select registered data
    logic useSevenOr;  // drop last term from OR
    logic enFromPin;   // enable from oeN
    logic enFromTerm;  // enable from last term
    logic enAlways;    // enable always
    logic fbFromReg;   // feedback from Q
    logic fbFromNeigh; // feedback from neighbour
  } cellCtrl_t;
endpackage

// File: rtl/palCellCtrl.sv
module palCellCtrl
  import palCellPkg::*;
(
  input  logic      globalMode0,
  input  logic      globalMode1,
  input  logic      cellMode,
  output cellMode_e mode,
  output cellCtrl_t ctrl
);
  always_comb begin
    unique case ({globalMode0, globalMode1, cellMode})
      3'b010:  mode = ModeReg;
      3'b100:  mode = ModeCombOut;
      3'b111:  mode = ModeIoNonReg;
      3'b011:  mode = ModeIoReg;
      default: mode = ModeInput;
    endcase
  end

  always_comb begin
    ctrl = '0;
    case (mode)
      ModeReg: begin
        ctrl.useReg    = 1'b1;
        ctrl.enFromPin = 1'b1;
        ctrl.fbFromReg = 1'b1;
      end
      ModeCombOut: begin
        ctrl.enAlways    = 1'b1;
        ctrl.fbFromNeigh = 1'b1;
      end
      ModeIoNonReg, ModeIoReg: begin
        ctrl.useSevenOr = 1'b1;
        ctrl.enFromTerm = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/palCellDatapath.sv
module palCellDatapath
  import palCellPkg::*;
#(
  parameter int Terms = NumTerms
) (
  input  logic             clk,
  input  logic             rst,
  input  cellCtrl_t        ctrl,
  input  logic             invertOut,
  input  logic             oeN,
  input  logic [Terms-1:0] productTerms,
  input  logic             pinIn,
  input  logic             neighborPin,
  output logic             regQ,
  output logic             pinData,
  output logic             pinDriveEn,
  output logic             feedback
);
  localparam int LastTerm = Terms - 1;

  logic fullOr;
  logic shortOr;
  logic sumSel;
  logic rawData;

  assign fullOr  = |productTerms;
  assign shortOr = |productTerms[LastTerm-1:0];
  assign sumSel  = ctrl.useSevenOr ? shortOr : fullOr;

  always_ff @(posedge clk) begin
    if (rst) regQ <= 1'b0;
    else     regQ <= fullOr;
  end

  assign rawData = ctrl.useReg ? regQ : sumSel;
  assign pinData = rawData ^ invertOut;

  always_comb begin
    pinDriveEn = 1'b0;
    if (ctrl.enAlways)        pinDriveEn = 1'b1;
    else if (ctrl.enFromPin)  pinDriveEn = ~oeN;
    else if (ctrl.enFromTerm) pinDriveEn = productTerms[LastTerm];
  end

  always_comb begin
    if (ctrl.fbFromReg)        feedback = regQ;
    else if (ctrl.fbFromNeigh) feedback = neighborPin;
    else                       feedback = pinIn;
  end
endmodule

// File: rtl/palCell.sv
module palCell
  import palCellPkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                globalMode0,
  input  logic                globalMode1,
  input  logic                cellMode,
  input  logic                invertOut,
  input  logic                oeN,
  input  logic [NumTerms-1:0] productTerms,
  input  logic                pinIn,
  input  logic                neighborPin,
  output logic                pinData,
  output logic                pinDriveEn,
  output logic                feedback
);
  cellMode_e mode;
  cellCtrl_t ctrl;
  logic      regQ;

  palCellCtrl u_ctrl (
    .globalMode0(globalMode0),
    .globalMode1(globalMode1),
    .cellMode(cellMode),
    .mode(mode),
    .ctrl(ctrl)
  );

  palCellDatapath #(.Terms(NumTerms)) u_dp (
    .clk(clk),
    .rst(rst),
    .ctrl(ctrl),
    .invertOut(invertOut),
    .oeN(oeN),
    .productTerms(productTerms),
    .pinIn(pinIn),
    .neighborPin(neighborPin),
    .regQ(regQ),
    .pinData(pinData),
    .pinDriveEn(pinDriveEn),
    .feedback(feedback)
  );
endmodule

// File: rtl/palCellChecker.sv
module palCellChecker
  import palCellPkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                globalMode0,
  input logic                globalMode1,
  input logic                cellMode,
  input logic                oeN,
  input logic [NumTerms-1:0] productTerms,
  input logic                pinIn,
  input logic                neighborPin,
  input logic                pinDriveEn,
  input logic                feedback,
  input logic                regQ
);
  logic isReg, isOut, isIo, isIn;
  assign isReg = {globalMode0, globalMode1, cellMode} == 3'b010;
  assign isOut = {globalMode0, globalMode1, cellMode} == 3'b100;
  assign isIo  = {globalMode1, cellMode} == 2'b11;
  assign isIn  = !(isReg || isOut || isIo);

  logic seenEdge;
  always_ff @(posedge clk) seenEdge <= 1'b1;

  a_r3_reg_oe: assert property (@(posedge clk) disable iff (rst)
    isReg |-> pinDriveEn == !oeN);
  a_r4_reg_fb: assert property (@(posedge clk) disable iff (rst)
    isReg |-> feedback == regQ);
  a_r5_out_en: assert property (@(posedge clk) disable iff (rst)
    isOut |-> pinDriveEn);
  a_r6_out_fb: assert property (@(posedge clk) disable iff (rst)
    isOut |-> feedback == neighborPin);
  a_r7_io_en: assert property (@(posedge clk) disable iff (rst)
    isIo |-> pinDriveEn == productTerms[NumTerms-1]);
  a_r8_pin_fb: assert property (@(posedge clk) disable iff (rst)
    (isIo || isIn) |-> feedback == pinIn);
  a_r9_in_off: assert property (@(posedge clk) disable iff (rst)
    isIn |-> !pinDriveEn);
  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    (seenEdge && !$past(rst)) |-> regQ == $past(|productTerms));
  a_r10_reset: assert property (@(posedge clk)
    (seenEdge && $past(rst)) |-> regQ == 1'b0);
endmodule

bind palCell palCellChecker u_chk (
  .clk(clk), .rst(rst), .globalMode0(globalMode0), .globalMode1(globalMode1),
  .cellMode(cellMode), .oeN(oeN), .productTerms(productTerms), .pinIn(pinIn),
  .neighborPin(neighborPin), .pinDriveEn(pinDriveEn), .feedback(feedback),
  .regQ(regQ)
);

// File: tb/palCell_bench.sv
module palCell_bench;
  localparam int ClkPeriod = 10;

  logic clk = 1'b0;
  logic rst;
  logic g0, g1, cm, inv, oeN, pinIn, neigh;
  logic [7:0] pt;
  logic pinData, pinDriveEn, feedback;

  int checks = 0;
  int fails = 0;
  bit modelQ;

  always #(ClkPeriod/2) clk = ~clk;

  palCell u_palCell (
    .clk(clk), .rst(rst), .globalMode0(g0), .globalMode1(g1), .cellMode(cm),
    .invertOut(inv), .oeN(oeN), .productTerms(pt), .pinIn(pinIn),
    .neighborPin(neigh), .pinData(pinData), .pinDriveEn(pinDriveEn),
    .feedback(feedback)
  );

  // Behavioural model: register tracked at each edge
  always @(posedge clk) modelQ <= rst ? 1'b0 : (|pt);

  task automatic chk1(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b (mode=%b%b%b pt=%h inv=%b)",
               tag, act, exp, g0, g1, cm, pt, inv);
    end
  endtask

  // Compare all outputs against the requirement model
  task automatic compareAll();
    logic eD, eE, eF;
    string m;
    case ({g0, g1, cm})
      3'b010: begin
        eD = modelQ ^ inv; eE = !oeN; eF = modelQ; m = "R2/R3/R4";
      end
      3'b100: begin
        eD = (|pt) ^ inv; eE = 1'b1; eF = neigh; m = "R5/R6";
      end
      3'b111, 3'b011: begin
        eD = (|pt[6:0]) ^ inv; eE = pt[7]; eF = pinIn; m = "R7/R8";
      end
      default: begin
        eD = pinData; eE = 1'b0; eF = pinIn; m = "R1/R9/R8";
      end
    endcase
    chk1({m, " data"}, pinData, eD);
    chk1({m, " enable"}, pinDriveEn, eE);
    chk1({m, " feedback"}, feedback, eF);
  endtask

  // apply stimulus at negedge, compare just before next posedge
  task automatic step(logic [2:0] md, logic i, logic o, logic [7:0] p,
                      logic pi, logic nb);
    @(negedge clk);
    {g0, g1, cm} = md; inv = i; oeN = o; pt = p; pinIn = pi; neigh = nb;
    #(ClkPeriod/4);
    compareAll();
  endtask

  initial begin
    #(ClkPeriod * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; {g0, g1, cm} = 3'b010; inv = 0; oeN = 0;
    pt = 8'hFF; pinIn = 0; neigh = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk1("R10 reset clears register", pinData, 1'b0);
    chk1("R10 reset feedback", feedback, 1'b0);
    rst = 1'b0;

    // R1 sweep of all eight mode combos with several patterns
    for (int md = 0; md < 8; md++)
      for (int k = 0; k < 6; k++)
        step(md[2:0], k[0], k[1], 8'(k * 37 + md), k[2], ~k[0]);

    // R2/R11: registered mode, data changes only after edge
    step(3'b010, 0, 0, 8'h00, 0, 0);
    step(3'b010, 0, 0, 8'h00, 0, 0);
    @(negedge clk); pt = 8'h80; #1;
    chk1("R11 no mid-cycle change", pinData, 1'b0);
    @(posedge clk); #1;
    chk1("R2 captured term7", pinData, 1'b1);
    step(3'b010, 1, 0, 8'h00, 0, 0);
    chk1("R2 inverted Q", pinData, 1'b0);
    step(3'b010, 1, 1, 8'h00, 0, 0);
    chk1("R3 oeN high disables", pinDriveEn, 1'b0);

    // R7: term 7 alone must not reach data in I/O modes
    step(3'b111, 0, 0, 8'h80, 1, 0);
    chk1("R7 term7 excluded", pinData, 1'b0);
    chk1("R7 term7 enables", pinDriveEn, 1'b1);
    step(3'b011, 1, 0, 8'h01, 0, 1);
    chk1("R7 seven-term inverted", pinData, 1'b0);
    // R5: term 7 does reach data in dedicated output
    step(3'b100, 0, 1, 8'h80, 0, 1);
    chk1("R5 term7 included", pinData, 1'b1);
    chk1("R6 neighbour feedback", feedback, 1'b1);
    // R9: input mode ignores terms and oeN
    step(3'b101, 0, 0, 8'hFF, 1, 0);
    chk1("R9 input mode disabled", pinDriveEn, 1'b0);
    chk1("R8 input mode feedback", feedback, 1'b1);

    // R10: mid-run reset
    step(3'b010, 0, 0, 8'hFF, 0, 0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; pt = 8'h00;
    #1; chk1("R10 mid-run reset", pinData, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule